// File: doc/BRIEF.md
# Enhanced Buffered Page Programmer

This block is a host-side sequencer that fills one complete page of a 16-bit parallel NOR flash through the device's enhanced buffered programming mode. After a single-cycle `start` it captures the page number and produces a timed series of bus write cycles. First come the three unlock-and-enter writes. Then comes the 258-write program command: a setup code, one data word for every page offset in ascending order, and a confirm code. The sequencer then waits for the device's ready/busy line and finishes with the two-write mode exit before it raises `done`.

The page contents come from a storage element outside the block. The sequencer presents an offset on `src_idx` and expects the matching word on `src_data` in the same cycle. Every bus write uses the same strobe shape: address and data settle for a set number of clocks, write enable goes low for a set number of clocks, and then everything holds. Chip enable stays low for the whole operation. If the device does not go busy and then return to ready within a timeout window, the sequencer sends the three-write abort reset in place of the mode exit and reports the failure with `error` alongside `done`.

Top module: `ebp_page_writer`

## Requirements
- R1: While reset is held and afterwards until a start, `flash_ce_n` and `flash_we_n` are high and `busy`, `done` and `error` are low.
- R2: An operation opens with three writes in this order: 0x00AA to address 0x000555, 0x0055 to 0x0002AA, then 0x0038 to 0x000555.
- R3: Next comes 0x0033 written to the page base, which is `{page_sel, 8'h00}`. It is followed by 256 data writes to offsets 0x00 to 0xFF in strictly ascending order, each to `{page_sel, offset}`, with the value that `src_data` returns while `src_idx` equals that offset. `page_sel` is captured at start.
- R4: The program command closes with 0x0029 written to the page base (offset 0x00).
- R5: After the confirm write there is no bus write and no `done` until `flash_rb` has gone low and then returned high. Then 0x0090 and 0x0000 are written to address 0, after which `done` pulses with `error` low.
- R6: Each write holds `flash_we_n` low for exactly PULSE_CLKS clocks. Address and data are stable for at least SETUP_CLKS clocks before the falling edge, stay constant while the strobe is low, and do not change for at least HOLD_CLKS clocks after it rises.
- R7: `flash_ce_n` is low exactly while `busy` is high, and `flash_we_n` goes low only while `flash_ce_n` is low.
- R8: If the busy-then-ready handshake does not complete within TIMEOUT_CLKS clocks of the confirm, the block writes 0x00AA to 0x000555, 0x0055 to 0x0002AA and 0x00F0 to 0x000555, then pulses `done` with `error` high.
- R9: `busy` rises in the clock after an accepted start and falls after `done`. A `start` or a change of `page_sel` during an operation has no effect on the write stream.
- R10: `done` lasts one clock, and `error` is high only in that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-clock request to program a page; accepted only when idle |
| page_sel | input | ADDR_W-OFS_W | Page number; supplies address bits above the page offset |
| src_idx | output | OFS_W | Page offset of the data word currently wanted |
| src_data | input | 16 | Word for `src_idx`, valid in the same clock |
| flash_rb | input | 1 | Device ready (1) / busy (0) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock end-of-operation pulse |
| error | output | 1 | Qualifies `done`: the operation timed out and was aborted |
| flash_addr | output | ADDR_W | Flash word address |
| flash_dq | output | 16 | Flash write data |
| flash_ce_n | output | 1 | Chip enable, active low |
| flash_we_n | output | 1 | Write enable strobe, active low |

## Verification
A wrong step counter or script selector shows up at the strobe that ends the faulty write. That write carries the wrong code, offset or address, and it is detected when `flash_we_n` rises. An off-by-one in the data burst therefore appears by the fifth write or, at the latest, at the confirm. A strobe-timing fault, such as a wrong pulse length or an address that moves too close to an edge, is seen within the same bus write. A fault in the ready/busy wait shows up as an exit write or a `done` that appears while the bench still holds the device busy, or as an abort that comes before the timeout window has passed.

// File: rtl/ebp_pkg.sv
// Shared constants and types for the enhanced buffered page programmer.
// Assumes a 16-bit flash data bus; the command codes are word-mode values.
package ebp_pkg;
    localparam int WORD_W = 16;

    // Which write script the sequencer is stepping through.
    typedef enum logic [1:0] {
        SCR_PROG  = 2'd0,
        SCR_EXIT  = 2'd1,
        SCR_ABORT = 2'd2
    } script_e;

    localparam logic [11:0] A_KEY1 = 12'h555;
    localparam logic [11:0] A_KEY2 = 12'h2AA;

    localparam logic [WORD_W-1:0] D_KEY1    = 16'h00AA;
    localparam logic [WORD_W-1:0] D_KEY2    = 16'h0055;
    localparam logic [WORD_W-1:0] D_ENTER   = 16'h0038;
    localparam logic [WORD_W-1:0] D_SETUP   = 16'h0033;
    localparam logic [WORD_W-1:0] D_CONFIRM = 16'h0029;
    localparam logic [WORD_W-1:0] D_LEAVE1  = 16'h0090;
    localparam logic [WORD_W-1:0] D_LEAVE2  = 16'h0000;
    localparam logic [WORD_W-1:0] D_ABORT   = 16'h00F0;
endpackage

// File: rtl/ebp_step_gen.sv
// Maps (script, step index) to the address/data of one bus write.
// Purely combinational. Program script: 3 entry writes, setup code,
// 2**OFS_W data writes, confirm. Assumes ADDR_W > OFS_W and ADDR_W >= 12.
module ebp_step_gen
    import ebp_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int OFS_W  = 8,
    parameter int IDX_W  = 9
) (
    input  script_e                  scr,
    input  logic [IDX_W-1:0]         idx,
    input  logic [ADDR_W-OFS_W-1:0]  blk,
    input  logic [WORD_W-1:0]        src_data,
    output logic [ADDR_W-1:0]        addr,
    output logic [WORD_W-1:0]        data,
    output logic                     last,
    output logic [OFS_W-1:0]         ofs
);
    localparam int PAGE = 1 << OFS_W;
    localparam logic [IDX_W-1:0] I_CONF = IDX_W'(PAGE + 4);

    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] key1;
    logic [ADDR_W-1:0] key2;

    assign base = {blk, {OFS_W{1'b0}}};
    assign key1 = ADDR_W'(A_KEY1);
    assign key2 = ADDR_W'(A_KEY2);
    // Data writes start at step 4; the offset is the step minus that.
    assign ofs  = OFS_W'(idx - IDX_W'(4));

    // Select the write for the current step of the current script.
    always_comb begin
        addr = key1;
        data = D_KEY1;
        last = 1'b0;
        case (scr)
            SCR_PROG: begin
                if (idx == IDX_W'(0)) begin
                    addr = key1; data = D_KEY1;
                end else if (idx == IDX_W'(1)) begin
                    addr = key2; data = D_KEY2;
                end else if (idx == IDX_W'(2)) begin
                    addr = key1; data = D_ENTER;
                end else if (idx == IDX_W'(3)) begin
                    addr = base; data = D_SETUP;
                end else if (idx == I_CONF) begin
                    addr = base; data = D_CONFIRM; last = 1'b1;
                end else begin
                    addr = {blk, ofs}; data = src_data;
                end
            end
            SCR_EXIT: begin
                addr = '0;
                data = (idx == IDX_W'(0)) ? D_LEAVE1 : D_LEAVE2;
                last = (idx == IDX_W'(1));
            end
            SCR_ABORT: begin
                if (idx == IDX_W'(0)) begin
                    addr = key1; data = D_KEY1;
                end else if (idx == IDX_W'(1)) begin
                    addr = key2; data = D_KEY2;
                end else begin
                    addr = key1; data = D_ABORT;
                end
                last = (idx == IDX_W'(2));
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ebp_bus_writer.sv
// Executes one flash bus write: latches address/data on go, keeps the
// strobe high SETUP_CLKS, low PULSE_CLKS, high HOLD_CLKS, then pulses fin.
// Assumes every timing parameter is at least 1 and go only arrives when idle.
module ebp_bus_writer #(
    parameter int ADDR_W     = 24,
    parameter int DATA_W     = 16,
    parameter int SETUP_CLKS = 2,
    parameter int PULSE_CLKS = 3,
    parameter int HOLD_CLKS  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              idle,
    output logic              fin,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_dq,
    output logic              bus_we_n
);
    localparam int TOTAL = SETUP_CLKS + PULSE_CLKS + HOLD_CLKS;
    localparam int CNT_W = $clog2(TOTAL);
    localparam logic [CNT_W-1:0] C_LO  = CNT_W'(SETUP_CLKS);
    localparam logic [CNT_W-1:0] C_HI  = CNT_W'(SETUP_CLKS + PULSE_CLKS);
    localparam logic [CNT_W-1:0] C_END = CNT_W'(TOTAL - 1);

    logic             active;
    logic [CNT_W-1:0] cnt;

    // Step through the write window and hold the bus values for it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            cnt      <= '0;
            fin      <= 1'b0;
            bus_addr <= '0;
            bus_dq   <= '0;
        end else begin
            fin <= 1'b0;
            if (!active) begin
                if (go) begin
                    active   <= 1'b1;
                    cnt      <= '0;
                    bus_addr <= wr_addr;
                    bus_dq   <= wr_data;
                end
            end else if (cnt == C_END) begin
                active <= 1'b0;
                fin    <= 1'b1;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    assign idle     = !active;
    assign bus_we_n = !(active && (cnt >= C_LO) && (cnt < C_HI));
endmodule

// File: rtl/ebp_ready_watch.sv
// After arm, waits for the synchronized ready/busy line to go busy and
// then ready (ok pulse), or for TIMEOUT_CLKS clocks (expired pulse).
// Assumes flash_rb is asynchronous to clk; two flops resynchronize it.
module ebp_ready_watch #(
    parameter int TIMEOUT_CLKS = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic rb,
    output logic ok,
    output logic expired
);
    localparam int T_W = $clog2(TIMEOUT_CLKS + 1);
    localparam logic [T_W-1:0] T_END = T_W'(TIMEOUT_CLKS - 1);

    typedef enum logic [1:0] {W_OFF, W_BUSY, W_READY} wst_e;

    wst_e           wst;
    logic [T_W-1:0] tcnt;
    logic           rb_meta;
    logic           rb_s;

    // Bring the ready/busy line into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rb_meta <= 1'b1;
            rb_s    <= 1'b1;
        end else begin
            rb_meta <= rb;
            rb_s    <= rb_meta;
        end
    end

    // Track the busy-then-ready handshake against the timeout window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wst     <= W_OFF;
            tcnt    <= '0;
            ok      <= 1'b0;
            expired <= 1'b0;
        end else begin
            ok      <= 1'b0;
            expired <= 1'b0;
            if (wst == W_OFF) begin
                if (arm) begin
                    wst  <= W_BUSY;
                    tcnt <= '0;
                end
            end else if (wst == W_READY && rb_s) begin
                ok  <= 1'b1;
                wst <= W_OFF;
            end else if (tcnt == T_END) begin
                expired <= 1'b1;
                wst     <= W_OFF;
            end else begin
                tcnt <= tcnt + T_W'(1);
                if (wst == W_BUSY && !rb_s) wst <= W_READY;
            end
        end
    end
endmodule

// File: rtl/ebp_page_writer.sv
// Sequencer for one enhanced buffered page program: entry, setup, full
// ascending data burst, confirm, ready/busy wait, then exit or abort.
// Assumes a 16-bit flash bus and a source that answers src_idx combinationally.
module ebp_page_writer
    import ebp_pkg::*;
#(
    parameter int ADDR_W       = 24,
    parameter int OFS_W        = 8,
    parameter int SETUP_CLKS   = 2,
    parameter int PULSE_CLKS   = 3,
    parameter int HOLD_CLKS    = 2,
    parameter int TIMEOUT_CLKS = 4096
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [ADDR_W-OFS_W-1:0] page_sel,
    output logic [OFS_W-1:0]        src_idx,
    input  logic [WORD_W-1:0]       src_data,
    input  logic                    flash_rb,
    output logic                    busy,
    output logic                    done,
    output logic                    error,
    output logic [ADDR_W-1:0]       flash_addr,
    output logic [WORD_W-1:0]       flash_dq,
    output logic                    flash_ce_n,
    output logic                    flash_we_n
);
    localparam int PAGE  = 1 << OFS_W;
    localparam int IDX_W = $clog2(PAGE + 5);
    localparam int BLK_W = ADDR_W - OFS_W;

    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_WAIT, ST_DONE} st_e;

    st_e               st;
    script_e           scr;
    logic [IDX_W-1:0]  idx;
    logic [BLK_W-1:0]  blk_q;
    logic              launched;
    logic              err_q;

    logic              go;
    logic              wr_idle;
    logic              wr_fin;
    logic [ADDR_W-1:0] step_addr;
    logic [WORD_W-1:0] step_data;
    logic              step_last;
    logic              arm;
    logic              rdy_ok;
    logic              rdy_exp;

    ebp_step_gen #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .IDX_W(IDX_W)) u_step (
        .scr      (scr),
        .idx      (idx),
        .blk      (blk_q),
        .src_data (src_data),
        .addr     (step_addr),
        .data     (step_data),
        .last     (step_last),
        .ofs      (src_idx)
    );

    ebp_bus_writer #(
        .ADDR_W(ADDR_W), .DATA_W(WORD_W), .SETUP_CLKS(SETUP_CLKS),
        .PULSE_CLKS(PULSE_CLKS), .HOLD_CLKS(HOLD_CLKS)
    ) u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .wr_addr  (step_addr),
        .wr_data  (step_data),
        .idle     (wr_idle),
        .fin      (wr_fin),
        .bus_addr (flash_addr),
        .bus_dq   (flash_dq),
        .bus_we_n (flash_we_n)
    );

    ebp_ready_watch #(.TIMEOUT_CLKS(TIMEOUT_CLKS)) u_watch (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (arm),
        .rb      (flash_rb),
        .ok      (rdy_ok),
        .expired (rdy_exp)
    );

    assign go  = (st == ST_RUN) && !launched && wr_idle;
    assign arm = (st == ST_RUN) && wr_fin && step_last && (scr == SCR_PROG);

    // Operation state, script position and page capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            scr      <= SCR_PROG;
            idx      <= '0;
            blk_q    <= '0;
            launched <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    st       <= ST_RUN;
                    scr      <= SCR_PROG;
                    idx      <= '0;
                    blk_q    <= page_sel;
                    launched <= 1'b0;
                    err_q    <= 1'b0;
                end
                ST_RUN: begin
                    if (go) launched <= 1'b1;
                    if (wr_fin) begin
                        launched <= 1'b0;
                        if (step_last) begin
                            st <= (scr == SCR_PROG) ? ST_WAIT : ST_DONE;
                        end else begin
                            idx <= idx + IDX_W'(1);
                        end
                    end
                end
                ST_WAIT: begin
                    if (rdy_ok) begin
                        st  <= ST_RUN;
                        scr <= SCR_EXIT;
                        idx <= '0;
                    end else if (rdy_exp) begin
                        st    <= ST_RUN;
                        scr   <= SCR_ABORT;
                        idx   <= '0;
                        err_q <= 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy       = (st != ST_IDLE);
    assign done       = (st == ST_DONE);
    assign error      = done && err_q;
    assign flash_ce_n = !busy;
endmodule

// File: rtl/ebp_page_writer_chk.sv
// Property checker for ebp_page_writer, attached by bind below.
// Observes ports only; counts strobe-low clocks to check the pulse width.
module ebp_page_writer_chk #(
    parameter int ADDR_W     = 24,
    parameter int PULSE_CLKS = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              error,
    input logic              flash_ce_n,
    input logic              flash_we_n,
    input logic [ADDR_W-1:0] flash_addr,
    input logic [15:0]       flash_dq
);
    logic [15:0] lo_cnt;

    // Count consecutive clocks with the write strobe low.
    always_ff @(posedge clk) begin
        if (!rst_n)           lo_cnt <= '0;
        else if (!flash_we_n) lo_cnt <= lo_cnt + 16'd1;
        else                  lo_cnt <= '0;
    end

    AST_WE_UNDER_CE: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_we_n |-> !flash_ce_n); // R7
    AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> flash_we_n); // R7
    AST_BUS_STILL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!flash_we_n && !$past(flash_we_n)) |-> ($stable(flash_addr) && $stable(flash_dq))); // R6
    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_we_n && lo_cnt != 16'd0) |-> (lo_cnt == 16'(PULSE_CLKS))); // R6
    AST_DONE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_ERROR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> done); // R10
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R9
endmodule

bind ebp_page_writer ebp_page_writer_chk #(
    .ADDR_W(ADDR_W), .PULSE_CLKS(PULSE_CLKS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .error      (error),
    .flash_ce_n (flash_ce_n),
    .flash_we_n (flash_we_n),
    .flash_addr (flash_addr),
    .flash_dq   (flash_dq)
);

// File: tb/ebp_page_writer_tb.sv
`timescale 1ns/1ps
// Bench: behavioural expected-write queue plus per-clock strobe/enable checks.
module ebp_page_writer_tb;
    localparam int AW    = 24;
    localparam int OW    = 8;
    localparam int SETUP = 2;
    localparam int PULSE = 3;
    localparam int HOLD  = 2;
    localparam int TMO   = 300;
    localparam int PAGE  = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [15:0]   page_sel = '0;
    logic [7:0]    src_idx;
    logic [15:0]   src_data;
    logic          flash_rb = 1'b1;
    logic          busy, done, error;
    logic [AW-1:0] flash_addr;
    logic [15:0]   flash_dq;
    logic          flash_ce_n, flash_we_n;

    int checks = 0;
    int errors = 0;
    int seed   = 0;

    always #2 clk = ~clk;

    function automatic logic [15:0] mk(input int s, input logic [7:0] i);
        return 16'(s * 499) ^ {i, ~i} ^ 16'(i * i);
    endfunction

    assign src_data = mk(seed, src_idx);

    ebp_page_writer #(
        .ADDR_W(AW), .OFS_W(OW), .SETUP_CLKS(SETUP), .PULSE_CLKS(PULSE),
        .HOLD_CLKS(HOLD), .TIMEOUT_CLKS(TMO)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .page_sel(page_sel),
        .src_idx(src_idx), .src_data(src_data), .flash_rb(flash_rb),
        .busy(busy), .done(done), .error(error), .flash_addr(flash_addr),
        .flash_dq(flash_dq), .flash_ce_n(flash_ce_n), .flash_we_n(flash_we_n)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Expected writes as {addr, data}; monitor state.
    logic [39:0] expq[$];
    int          wr_seen = 0;
    bit          arm_rb = 0, rb_hold = 0, conf_flag = 0;
    string       tail_tag = "R5";
    logic        prev_we = 1'b1;
    logic [39:0] prev_val = '0;
    logic [39:0] cur;
    logic [39:0] e;
    int          run_len = 0, lo_n = 0;
    bit          prev_strobed = 0;

    function automatic string tag_of(input int n);
        if (n < 3)   return "R2";
        if (n < 260) return "R3";
        if (n == 260) return "R4";
        return tail_tag;
    endfunction

    // Per-clock monitor, sampled on the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            cur = {flash_addr, flash_dq};
            chk(flash_ce_n == !busy, "R7", "ce_n vs busy", 64'(flash_ce_n), 64'(!busy));
            if (!flash_we_n) chk(!flash_ce_n, "R7", "strobe without ce", 64'(flash_ce_n), 64'd0);
            if (cur != prev_val) begin
                if (prev_strobed)
                    chk(run_len >= SETUP + PULSE + HOLD, "R6", "bus hold window",
                        64'(run_len), 64'(SETUP + PULSE + HOLD));
                run_len = 1;
                prev_strobed = 0;
            end else begin
                run_len++;
            end
            if (!flash_we_n && prev_we) begin
                chk(run_len >= SETUP + 1, "R6", "setup before strobe", 64'(run_len), 64'(SETUP + 1));
                if (rb_hold) chk(0, "R5", "write while device busy", 64'(cur), 64'd0);
                lo_n = 1;
                prev_strobed = 1;
            end else if (!flash_we_n) begin
                chk(cur == prev_val, "R6", "bus moved during strobe", 64'(cur), 64'(prev_val));
                lo_n++;
            end else if (!prev_we) begin
                chk(lo_n == PULSE, "R6", "strobe width", 64'(lo_n), 64'(PULSE));
                if (expq.size() == 0) begin
                    chk(0, tag_of(wr_seen), "unexpected write", 64'(cur), 64'd0);
                end else begin
                    e = expq.pop_front();
                    chk(cur == e, tag_of(wr_seen), "write addr/data", 64'(cur), 64'(e));
                end
                wr_seen++;
                if (wr_seen == 261) begin
                    conf_flag = 1;
                    if (arm_rb) rb_hold = 1;
                end
            end
            if (done && rb_hold) chk(0, "R5", "done while device busy", 64'd1, 64'd0);
            prev_we  = flash_we_n;
            prev_val = cur;
        end
    end

    task automatic load_prog(input logic [15:0] pg, input int s);
        logic [AW-1:0] base;
        base = {pg, 8'h00};
        expq.delete();
        expq.push_back({24'h000555, 16'h00AA});
        expq.push_back({24'h0002AA, 16'h0055});
        expq.push_back({24'h000555, 16'h0038});
        expq.push_back({base, 16'h0033});
        for (int i = 0; i < PAGE; i++)
            expq.push_back({pg, 8'(i), mk(s, 8'(i))});
        expq.push_back({base, 16'h0029});
    endtask

    task automatic begin_op(input logic [15:0] pg, input int s);
        seed = s;
        wr_seen = 0;
        conf_flag = 0;
        rb_hold = 0;
        @(negedge clk);
        page_sel = pg;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R9", "busy after start", 64'(busy), 64'd1);
    endtask

    task automatic wait_conf();
        int n = 0;
        while (!conf_flag && n < 20000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic wait_done(input bit exp_err, input string tag, output int n);
        n = 0;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk(done == 1'b1, tag, "done reached", 64'(done), 64'd1);
        chk(error == exp_err, tag, "error flag", 64'(error), 64'(exp_err));
        chk(expq.size() == 0, tag, "writes left over", 64'(expq.size()), 64'd0);
        @(negedge clk);
        chk(!done && !error, "R10", "done one clock", 64'({done, error}), 64'd0);
        chk(!busy && flash_ce_n, "R9", "idle after done", 64'({busy, flash_ce_n}), 64'd1);
    endtask

    task automatic run_normal(input logic [15:0] pg, input int s, input bit disturb);
        int n;
        load_prog(pg, s);
        expq.push_back({24'h000000, 16'h0090});
        expq.push_back({24'h000000, 16'h0000});
        arm_rb = 1;
        tail_tag = "R5";
        begin_op(pg, s);
        if (disturb) begin
            // R9: a second start and a new page mid-burst must change nothing
            repeat (40) @(negedge clk);
            page_sel = ~pg;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(busy == 1'b1, "R9", "busy during op", 64'(busy), 64'd1);
        end
        wait_conf();
        repeat (15) @(negedge clk);
        flash_rb = 1'b0;
        repeat (25) @(negedge clk);
        flash_rb = 1'b1;
        rb_hold = 0;
        wait_done(1'b0, "R5", n);
    endtask

    task automatic run_timeout(input logic [15:0] pg, input int s, input bit stuck_busy);
        int n;
        load_prog(pg, s);
        expq.push_back({24'h000555, 16'h00AA});
        expq.push_back({24'h0002AA, 16'h0055});
        expq.push_back({24'h000555, 16'h00F0});
        arm_rb = 0;
        tail_tag = "R8";
        begin_op(pg, s);
        wait_conf();
        if (stuck_busy) flash_rb = 1'b0;
        wait_done(1'b1, "R8", n);
        chk(n >= TMO, "R8", "abort not before timeout", 64'(n), 64'(TMO));
        flash_rb = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(flash_ce_n && flash_we_n && !busy && !done && !error, "R1", "outputs in reset",
            64'({flash_ce_n, flash_we_n, busy, done, error}), 64'b11000);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(flash_ce_n && flash_we_n && !busy && !done, "R1", "idle after reset",
            64'({flash_ce_n, flash_we_n, busy, done}), 64'b1100);
        run_normal(16'h1234, 1, 1'b0);
        run_normal(16'hFFFF, 2, 1'b1);
        run_timeout(16'h00A5, 3, 1'b0);
        run_timeout(16'h5A00, 4, 1'b1);
        run_normal(16'h0000, 5, 1'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule